// File: doc/BRIEF.md
# Combining Request Queue

This block is the request queue at the memory-facing output of one 2x2 switch in a processor-to-memory network. Each cycle it can take one request from each of the two processor-facing inputs, and it hands requests to the memory side in arrival order. While a request waits, every new arrival is compared with it. When two requests of the same kind meet on the same address, they become one entry. For two fetch-and-adds, the entry carries the sum of the two increments. For two loads, one load is kept. For two stores, the newer value is kept. When a merged entry leaves, a decombine record goes out beside it. A wait buffer uses that record to split the single reply back into two replies.

A merge never uses up a slot. An entry merges at most once, so combining is strictly two-way. The head entry can still take a partner while it stalls, but not in the cycle it leaves. Back-pressure is taken from occupancy alone, so an input is never refused because of a compare result.

Top module: `cq_merge_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `out_valid` and `wb_valid` are low, and both `in0_ready` and `in1_ready` are high.
- R2: A request word is packed `{op[1:0], addr, src, data}`. Requests that do not merge leave in acceptance order. When both inputs are accepted in one cycle, the input 0 request goes before the input 1 request.
- R3: A request accepted into an empty queue is presented on `out_valid`/`out_req` after exactly one rising edge.
- R4: Opcode 2'b10 is fetch-and-add. Two fetch-and-adds to one address merge into one request. Its data field is the sum of both increments modulo 2^32. Its `src` is the earlier requester's, and it keeps the earlier request's place in the order.
- R5: While a merged entry is at the head, `wb_valid` is high with `out_valid`. Both are consumed by the same `out_ready` handshake. `wb_rec` is packed `{op, addr, src_earlier, src_later, earlier_data}`. For a fetch-and-add, earlier_data is the earlier increment.
- R6: Opcode 2'b00 is load. Two loads to one address merge into one forwarded load, and a decombine record is emitted.
- R7: Opcode 2'b01 is store. Two stores to one address merge into one store that carries the later value, and a record is emitted.
- R8: Requests with different opcodes, or with different addresses, are never merged. Opcode 2'b11 never merges.
- R9: An entry that already holds a merged pair is not merged again. A third matching request takes a slot of its own.
- R10: The head entry in the cycle it is being dequeued cannot take a partner. A matching arrival in that cycle takes a new slot.
- R11: `in0_ready` is high while at least one slot is free. `in1_ready` is high while two slots are free, or while one is free and `in0_valid` is low. A refused request leaves the queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Input 0 request present |
| in0_req | input | 53 | Input 0 request word |
| in0_ready | output | 1 | Input 0 can be accepted |
| in1_valid | input | 1 | Input 1 request present |
| in1_req | input | 53 | Input 1 request word |
| in1_ready | output | 1 | Input 1 can be accepted |
| out_valid | output | 1 | Head request present toward memory |
| out_req | output | 53 | Head request word |
| out_ready | input | 1 | Memory side takes the head this cycle |
| wb_valid | output | 1 | Decombine record present with the head |
| wb_rec | output | 56 | Decombine record for the wait buffer |

## Verification
Request pairs are driven on the two inputs, either in successive cycles or in the same cycle. They cover matching fetch-and-adds, matching loads, matching stores, a different address, a different opcode and the reserved opcode. Each pair shows whether the block merged the two requests and, if so, what data and record it produced. A carry-out of the adder checks that the sum wraps. A queue filled to capacity checks that the ready rule holds and that order is kept. A third matching request shows that an already merged entry is not merged again. An arrival in the same cycle the head leaves shows that the departing head takes no partner.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FADD  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  // Reserved opcode never combines.
  function automatic logic op_mergeable(op_e op);
    return op != OP_RSVD;
  endfunction

endpackage

// File: rtl/cq_match.sv
module cq_match
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig,
  input  op_e              e_op   [DEPTH],
  input  logic [AW-1:0]    e_addr [DEPTH],
  input  op_e              k_op,
  input  logic [AW-1:0]    k_addr,
  output logic             hit,
  output logic [PW-1:0]    idx
);

  logic [DEPTH-1:0] eq;

  // One comparator per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = elig[g] && (e_op[g] == k_op) && (e_addr[g] == k_addr);
  end

  // Lowest slot index wins.
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = PW'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/cq_ring.sv
module cq_ring
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int SW    = 3,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  // allocation from input 0 (may already be a same-cycle pair)
  input  logic             a0_en,
  input  op_e              a0_op,
  input  logic [AW-1:0]    a0_addr,
  input  logic [SW-1:0]    a0_src,
  input  logic [DW-1:0]    a0_data,
  input  logic             a0_comb,
  input  logic [SW-1:0]    a0_src2,
  input  logic [DW-1:0]    a0_saved,
  // allocation from input 1
  input  logic             a1_en,
  input  op_e              a1_op,
  input  logic [AW-1:0]    a1_addr,
  input  logic [SW-1:0]    a1_src,
  input  logic [DW-1:0]    a1_data,
  // merges into waiting entries
  input  logic             m0_en,
  input  logic [PW-1:0]    m0_idx,
  input  logic [DW-1:0]    m0_data,
  input  logic [SW-1:0]    m0_src2,
  input  logic             m1_en,
  input  logic [PW-1:0]    m1_idx,
  input  logic [DW-1:0]    m1_data,
  input  logic [SW-1:0]    m1_src2,
  // storage view
  output op_e              e_op    [DEPTH],
  output logic [AW-1:0]    e_addr  [DEPTH],
  output logic [SW-1:0]    e_src   [DEPTH],
  output logic [DW-1:0]    e_data  [DEPTH],
  output logic [SW-1:0]    e_src2  [DEPTH],
  output logic [DW-1:0]    e_saved [DEPTH],
  output logic [DEPTH-1:0] e_comb,
  output logic [DEPTH-1:0] occ,
  output logic [PW-1:0]    head,
  output logic [CW-1:0]    count
);

  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] tail, slot1;

  assign tail  = head_q + cnt_q[PW-1:0];
  assign slot1 = a0_en ? tail + PW'(1) : tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= head_q + PW'(1);
      cnt_q <= cnt_q + CW'(a0_en) + CW'(a1_en) - CW'(pop);
    end
  end

  // Payload storage: no reset, occupancy qualifies every slot.
  always_ff @(posedge clk) begin
    if (a0_en) begin
      e_op[tail]    <= a0_op;
      e_addr[tail]  <= a0_addr;
      e_src[tail]   <= a0_src;
      e_data[tail]  <= a0_data;
      e_comb[tail]  <= a0_comb;
      e_src2[tail]  <= a0_src2;
      e_saved[tail] <= a0_saved;
    end
    if (a1_en) begin
      e_op[slot1]   <= a1_op;
      e_addr[slot1] <= a1_addr;
      e_src[slot1]  <= a1_src;
      e_data[slot1] <= a1_data;
      e_comb[slot1] <= 1'b0;
    end
    if (m0_en) begin
      e_saved[m0_idx] <= e_data[m0_idx];
      e_data[m0_idx]  <= m0_data;
      e_src2[m0_idx]  <= m0_src2;
      e_comb[m0_idx]  <= 1'b1;
    end
    if (m1_en) begin
      e_saved[m1_idx] <= e_data[m1_idx];
      e_data[m1_idx]  <= m1_data;
      e_src2[m1_idx]  <= m1_src2;
      e_comb[m1_idx]  <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    logic [PW-1:0] off;
    assign off    = PW'(g) - head_q;
    assign occ[g] = {1'b0, off} < cnt_q;
  end

  assign head  = head_q;
  assign count = cnt_q;

endmodule

// File: rtl/cq_merge_queue.sv
module cq_merge_queue
  import cq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 16,
  parameter int SW     = 3,
  parameter int DW     = 32,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1,
  localparam int REQ_W = 2 + AW + SW + DW,
  localparam int REC_W = 2 + AW + 2 * SW + DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in0_valid,
  input  logic [REQ_W-1:0] in0_req,
  output logic             in0_ready,
  input  logic             in1_valid,
  input  logic [REQ_W-1:0] in1_req,
  output logic             in1_ready,
  output logic             out_valid,
  output logic [REQ_W-1:0] out_req,
  input  logic             out_ready,
  output logic             wb_valid,
  output logic [REC_W-1:0] wb_rec
);

  function automatic logic [DW-1:0] fold(op_e op, logic [DW-1:0] old_v, logic [DW-1:0] new_v);
    case (op)
      OP_FADD:  return old_v + new_v;
      OP_STORE: return new_v;
      default:  return old_v;
    endcase
  endfunction

  // Unpack inputs.
  op_e           o0, o1;
  logic [AW-1:0] ad0, ad1;
  logic [SW-1:0] s0, s1;
  logic [DW-1:0] d0, d1;

  assign o0  = op_e'(in0_req[REQ_W-1 -: 2]);
  assign ad0 = in0_req[DW+SW +: AW];
  assign s0  = in0_req[DW +: SW];
  assign d0  = in0_req[DW-1:0];
  assign o1  = op_e'(in1_req[REQ_W-1 -: 2]);
  assign ad1 = in1_req[DW+SW +: AW];
  assign s1  = in1_req[DW +: SW];
  assign d1  = in1_req[DW-1:0];

  // Storage view.
  op_e              e_op    [DEPTH];
  logic [AW-1:0]    e_addr  [DEPTH];
  logic [SW-1:0]    e_src   [DEPTH];
  logic [DW-1:0]    e_data  [DEPTH];
  logic [SW-1:0]    e_src2  [DEPTH];
  logic [DW-1:0]    e_saved [DEPTH];
  logic [DEPTH-1:0] e_comb, occ;
  logic [PW-1:0]    head;
  logic [CW-1:0]    occ_cnt;

  logic acc0, acc1, pop;
  assign in0_ready = occ_cnt < CW'(DEPTH);
  assign in1_ready = (occ_cnt < CW'(DEPTH - 1)) ||
                     ((occ_cnt == CW'(DEPTH - 1)) && !in0_valid);
  assign acc0 = in0_valid && in0_ready;
  assign acc1 = in1_valid && in1_ready;
  assign out_valid = occ_cnt != '0;
  assign pop = out_valid && out_ready;

  // Eligibility: waiting, not yet merged, not leaving this cycle.
  logic [DEPTH-1:0] elig0, elig1;
  logic             mh0, mh1, hit0, hit1;
  logic [PW-1:0]    mi0, mi1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign elig0[g] = occ[g] && !e_comb[g] && !(pop && (head == PW'(g)));
    assign elig1[g] = elig0[g] && !(hit0 && (mi0 == PW'(g)));
  end

  cq_match #(.DEPTH(DEPTH), .AW(AW)) u_match0 (
    .elig(elig0), .e_op(e_op), .e_addr(e_addr),
    .k_op(o0), .k_addr(ad0), .hit(mh0), .idx(mi0)
  );

  cq_match #(.DEPTH(DEPTH), .AW(AW)) u_match1 (
    .elig(elig1), .e_op(e_op), .e_addr(e_addr),
    .k_op(o1), .k_addr(ad1), .hit(mh1), .idx(mi1)
  );

  assign hit0 = acc0 && op_mergeable(o0) && mh0;
  assign hit1 = acc1 && op_mergeable(o1) && mh1;

  // Same-cycle pairing of the two arrivals.
  logic pair;
  assign pair = acc0 && acc1 && !hit0 && !hit1 && op_mergeable(o0) &&
                (o0 == o1) && (ad0 == ad1);

  logic a0_en, a1_en;
  assign a0_en = acc0 && !hit0;
  assign a1_en = acc1 && !hit1 && !pair;

  cq_ring #(.DEPTH(DEPTH), .AW(AW), .SW(SW), .DW(DW)) u_ring (
    .clk(clk), .rst(rst), .pop(pop),
    .a0_en(a0_en), .a0_op(o0), .a0_addr(ad0), .a0_src(s0),
    .a0_data(pair ? fold(o0, d0, d1) : d0),
    .a0_comb(pair), .a0_src2(s1), .a0_saved(d0),
    .a1_en(a1_en), .a1_op(o1), .a1_addr(ad1), .a1_src(s1), .a1_data(d1),
    .m0_en(hit0), .m0_idx(mi0), .m0_data(fold(o0, e_data[mi0], d0)), .m0_src2(s0),
    .m1_en(hit1), .m1_idx(mi1), .m1_data(fold(o1, e_data[mi1], d1)), .m1_src2(s1),
    .e_op(e_op), .e_addr(e_addr), .e_src(e_src), .e_data(e_data),
    .e_src2(e_src2), .e_saved(e_saved), .e_comb(e_comb),
    .occ(occ), .head(head), .count(occ_cnt)
  );

  assign out_req  = {e_op[head], e_addr[head], e_src[head], e_data[head]};
  assign wb_valid = out_valid && e_comb[head];
  assign wb_rec   = {e_op[head], e_addr[head], e_src[head], e_src2[head], e_saved[head]};

endmodule

// File: rtl/cq_merge_queue_chk.sv
module cq_merge_queue_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in0_valid,
  input logic          in0_ready,
  input logic          in1_ready,
  input logic          out_valid,
  input logic          wb_valid,
  input logic [CW-1:0] occ_cnt
);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !wb_valid));

  // R5
  record_with_head_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> out_valid);

  // R3
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (in0_valid && in0_ready) |=> out_valid);

  // R11
  ready_order_chk: assert property (@(posedge clk) disable iff (rst)
    in1_ready |-> in0_ready);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ_cnt <= CW'(DEPTH));

endmodule

bind cq_merge_queue cq_merge_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in0_valid(in0_valid), .in0_ready(in0_ready),
  .in1_ready(in1_ready), .out_valid(out_valid), .wb_valid(wb_valid),
  .occ_cnt(occ_cnt)
);

// File: tb/cq_merge_queue_tb.sv
`timescale 1ns/100ps
module cq_merge_queue_tb;

  localparam int REQ_W = 53;
  localparam int REC_W = 56;

  logic clk = 1'b0;
  logic rst;
  logic in0_valid, in1_valid, out_ready;
  logic [REQ_W-1:0] in0_req, in1_req;
  logic in0_ready, in1_ready, out_valid, wb_valid;
  logic [REQ_W-1:0] out_req;
  logic [REC_W-1:0] wb_rec;

  always #2.5 clk = ~clk;

  cq_merge_queue u_dut (
    .clk(clk), .rst(rst),
    .in0_valid(in0_valid), .in0_req(in0_req), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_req(in1_req), .in1_ready(in1_ready),
    .out_valid(out_valid), .out_req(out_req), .out_ready(out_ready),
    .wb_valid(wb_valid), .wb_rec(wb_rec)
  );

  int tests = 0;
  int fails = 0;

  typedef struct packed {
    logic [1:0]  op_a;
    logic [15:0] addr_a;
    logic [31:0] dat_a;
    logic [1:0]  op_b;
    logic [15:0] addr_b;
    logic [31:0] dat_b;
    logic        same;
    logic [3:0]  exp_n;
    logic [31:0] exp_data;
    logic        exp_wb;
    logic [31:0] exp_saved;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 16'h0010, 32'd5, 2'b10, 16'h0010, 32'd7, 1'b0, 4'd1, 32'd12, 1'b1, 32'd5, 4'd4},            // R4
    '{2'b10, 16'h0010, 32'd5, 2'b10, 16'h0010, 32'd7, 1'b1, 4'd1, 32'd12, 1'b1, 32'd5, 4'd4},            // R4 same cycle
    '{2'b10, 16'h0010, 32'd5, 2'b10, 16'h0011, 32'd7, 1'b0, 4'd2, 32'd5, 1'b0, 32'd0, 4'd8},             // R8 address
    '{2'b00, 16'h0020, 32'd0, 2'b00, 16'h0020, 32'd0, 1'b0, 4'd1, 32'd0, 1'b1, 32'd0, 4'd6},             // R6
    '{2'b01, 16'h0030, 32'd9, 2'b01, 16'h0030, 32'd4, 1'b0, 4'd1, 32'd4, 1'b1, 32'd9, 4'd7},             // R7
    '{2'b10, 16'h0040, 32'd3, 2'b00, 16'h0040, 32'd0, 1'b0, 4'd2, 32'd3, 1'b0, 32'd0, 4'd8},             // R8 opcode
    '{2'b10, 16'h0050, 32'hFFFFFFFF, 2'b10, 16'h0050, 32'd2, 1'b1, 4'd1, 32'd1, 1'b1, 32'hFFFFFFFF, 4'd4}, // R4 wrap
    '{2'b01, 16'h0030, 32'd9, 2'b01, 16'h0030, 32'd4, 1'b1, 4'd1, 32'd4, 1'b1, 32'd9, 4'd7},             // R7 same cycle
    '{2'b11, 16'h0060, 32'd1, 2'b11, 16'h0060, 32'd2, 1'b0, 4'd2, 32'd1, 1'b0, 32'd0, 4'd8},             // R8 reserved
    '{2'b10, 16'h0070, 32'd1, 2'b01, 16'h0070, 32'd2, 1'b1, 4'd2, 32'd1, 1'b0, 32'd0, 4'd2}              // R2 order
  };

  logic [REQ_W-1:0] cap_req [16];
  logic             cap_wb  [16];
  logic [REC_W-1:0] cap_rec [16];
  int               n_cap;

  function automatic logic [REQ_W-1:0] mk(logic [1:0] op, logic [15:0] a, logic [2:0] s, logic [31:0] d);
    return {op, a, s, d};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    in0_valid = 1'b0;
    in1_valid = 1'b0;
  endtask

  task automatic drain();
    n_cap = 0;
    out_ready = 1'b1;
    while (out_valid && n_cap < 16) begin
      cap_req[n_cap] = out_req;
      cap_wb[n_cap]  = wb_valid;
      cap_rec[n_cap] = wb_rec;
      n_cap++;
      step();
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle();
    out_ready = 1'b0;
    in0_req = '0;
    in1_req = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "wb_valid", 64'(wb_valid), 64'd0);
    chk("R1", "in0_ready", 64'(in0_ready), 64'd1);
    chk("R1", "in1_ready", 64'(in1_ready), 64'd1);
    rst = 1'b0;
    step();

    // Vector table
    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[k].rq);
      in0_req = mk(VECS[k].op_a, VECS[k].addr_a, 3'd1, VECS[k].dat_a);
      in1_req = mk(VECS[k].op_b, VECS[k].addr_b, 3'd2, VECS[k].dat_b);
      if (VECS[k].same) begin
        in0_valid = 1'b1; in1_valid = 1'b1;
        step();
      end else begin
        in0_valid = 1'b1;
        step();
        in0_valid = 1'b0; in1_valid = 1'b1;
        step();
      end
      idle();
      drain();
      chk(rq, "count", 64'(n_cap), 64'(VECS[k].exp_n));
      chk(rq, "data", 64'(cap_req[0][31:0]), 64'(VECS[k].exp_data));
      chk(rq, "src", 64'(cap_req[0][34:32]), 64'd1);
      chk(rq, "wb_valid", 64'(cap_wb[0]), 64'(VECS[k].exp_wb));
      if (VECS[k].exp_wb) begin
        // R5 record fields
        chk("R5", "rec saved", 64'(cap_rec[0][31:0]), 64'(VECS[k].exp_saved));
        chk("R5", "rec src_later", 64'(cap_rec[0][34:32]), 64'd2);
        chk("R5", "rec src_earlier", 64'(cap_rec[0][37:35]), 64'd1);
        chk("R5", "rec addr", 64'(cap_rec[0][53:38]), 64'(VECS[k].addr_a));
        chk("R5", "rec op", 64'(cap_rec[0][55:54]), 64'(VECS[k].op_a));
      end
      if (VECS[k].exp_n == 4'd2) begin
        // R2 second request follows unchanged
        chk("R2", "second data", 64'(cap_req[1][31:0]), 64'(VECS[k].dat_b));
        chk("R2", "second wb", 64'(cap_wb[1]), 64'd0);
      end
    end

    // R3 and R10: latency from empty, departing head takes no partner
    out_ready = 1'b1;
    in0_req = mk(2'b10, 16'h0090, 3'd1, 32'd1);
    in0_valid = 1'b1;
    step();
    chk("R3", "out_valid after one edge", 64'(out_valid), 64'd1);
    chk("R3", "head data", 64'(out_req[31:0]), 64'd1);
    in0_req = mk(2'b10, 16'h0090, 3'd2, 32'd2);
    chk("R10", "departing head wb", 64'(wb_valid), 64'd0);
    step();
    idle();
    chk("R10", "new slot valid", 64'(out_valid), 64'd1);
    chk("R10", "new slot data", 64'(out_req[31:0]), 64'd2);
    chk("R10", "new slot wb", 64'(wb_valid), 64'd0);
    step();
    chk("R10", "drained", 64'(out_valid), 64'd0);
    out_ready = 1'b0;

    // R9: a third matching request is not merged into a pair
    in0_req = mk(2'b10, 16'h0080, 3'd1, 32'd1);
    in1_req = mk(2'b10, 16'h0080, 3'd2, 32'd2);
    in0_valid = 1'b1; in1_valid = 1'b1;
    step();
    in1_valid = 1'b0;
    in0_req = mk(2'b10, 16'h0080, 3'd3, 32'd4);
    step();
    idle();
    drain();
    chk("R9", "count", 64'(n_cap), 64'd2);
    chk("R9", "pair sum", 64'(cap_req[0][31:0]), 64'd3);
    chk("R9", "pair wb", 64'(cap_wb[0]), 64'd1);
    chk("R9", "third data", 64'(cap_req[1][31:0]), 64'd4);
    chk("R9", "third wb", 64'(cap_wb[1]), 64'd0);

    // R11: fill to capacity, ready rule, refusal; R2 order
    for (int i = 0; i < 8; i++) begin
      in0_req = mk(2'b10, 16'h0100 + 16'(i), 3'd1, 32'(i));
      if (i == 7) begin
        in0_valid = 1'b0;
        #1;
        chk("R11", "in1_ready one free, in0 idle", 64'(in1_ready), 64'd1);
        in0_valid = 1'b1;
        #1;
        chk("R11", "in1_ready one free, in0 busy", 64'(in1_ready), 64'd0);
      end
      in0_valid = 1'b1;
      step();
    end
    chk("R11", "in0_ready full", 64'(in0_ready), 64'd0);
    chk("R11", "in1_ready full", 64'(in1_ready), 64'd0);
    in0_req = mk(2'b10, 16'h01FF, 3'd1, 32'd9);
    in1_req = mk(2'b10, 16'h01FE, 3'd2, 32'd9);
    in0_valid = 1'b1; in1_valid = 1'b1;
    step();
    idle();
    drain();
    chk("R11", "refused left no trace", 64'(n_cap), 64'd8);
    for (int i = 0; i < 8; i++) begin
      chk("R2", "fifo order", 64'(cap_req[i][50:35]), 64'(16'h0100 + 16'(i)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule